// File: doc/BRIEF.md
# Dock Set-Instruction Register Update Unit

This unit decodes and carries out the register-setting instruction of a dock. The instruction holds a 2-bit source selector, a 3-bit destination selector and a 14-bit payload. When the instruction comes on deck, the unit decodes the selector pair and captures the literal, extended as needed, in an internal literal latch. When the execute strobe arrives, it drives one write enable and the new value toward one of these dock registers: the outer loop counter, the inner loop counter, the torpedo acknowledgment path latch, the word-wide data latch, or the two user flags.

Flag updates come from two 6-bit truth tables held in the payload. Each table is evaluated on the flag values from before the update. A write of zero to the outer loop counter also raises an unseal pulse for the hatch. The unit does not evaluate predicates. The surrounding dock raises the execute strobe only for an instruction that is to execute.

The instruction enters on `op_i` with this layout: [18:17] source, [16:14] destination, [13:0] payload.

Top module: `dock_set_unit`

## Requirements
- R1: On execute, destination 000 writes the outer counter. Source 00 gives the payload's low OLC_W bits, source 01 gives the data latch's low OLC_W bits, and source 10 gives the current counter minus one, saturating at zero.
- R2: On execute, destination 001 writes the inner counter. Source 00 gives the payload's low ILC_W bits, source 01 gives the data latch's low ILC_W bits, and source 10 raises `ilc_inf_o` with `ilc_o` at zero.
- R3: On execute, source 00 with destination 010 writes the payload's low TAPL_W bits to the torpedo acknowledgment path latch.
- R4: On execute, destination 100 writes the payload to the data latch. Source 01 zero-extends it to DATA_W bits and source 10 fills the upper bits with ones.
- R5: On execute, destination 111 (any source) writes both flags. The new A comes from the table in payload[11:6] and the new B from the table in payload[5:0]. In each table, bit 5 selects A, bit 4 selects not-A, bit 3 selects B, bit 2 selects not-B, bit 1 selects C and bit 0 selects not-C. The new flag is the OR of the selected terms, evaluated on the flag inputs from before the update.
- R6: The literal and the decoded selectors are captured on the `load_i` edge. Later changes on `op_i` do not affect what the pending instruction writes. No write enable is raised while `exec_i` is low.
- R7: `unseal_o` is high exactly when a write of zero to the outer counter occurs.
- R8: Any other source/destination combination raises no write enable when executed.
- R9: Each load allows one execution. A second `exec_i` cycle without a new load, or an `exec_i` after reset with no load, raises no write enable.
- R10: At most one write enable is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Instruction comes on deck; capture `op_i` |
| op_i | input | 19 | Source [18:17], destination [16:14], payload [13:0] |
| exec_i | input | 1 | Execute strobe for the pending instruction |
| data_i | input | DATA_W | Current data latch value |
| olc_i | input | OLC_W | Current outer loop counter |
| flag_a_i | input | 1 | Current flag A |
| flag_b_i | input | 1 | Current flag B |
| flag_c_i | input | 1 | Current flag C |
| olc_we_o | output | 1 | Outer counter write enable |
| olc_o | output | OLC_W | New outer counter value |
| unseal_o | output | 1 | Outer counter written to zero |
| ilc_we_o | output | 1 | Inner counter write enable |
| ilc_o | output | ILC_W | New inner counter value |
| ilc_inf_o | output | 1 | New inner counter value is infinity |
| tapl_we_o | output | 1 | Torpedo acknowledgment path write enable |
| tapl_o | output | TAPL_W | New path value |
| data_we_o | output | 1 | Data latch write enable |
| data_o | output | DATA_W | New data latch value |
| flags_we_o | output | 1 | Flags write enable |
| flag_a_o | output | 1 | New flag A |
| flag_b_o | output | 1 | New flag B |

## Verification
A wrong captured selector or literal shows in the execute cycle. The symptom is the wrong write enable, a wrong extension pattern in the upper data bits, or a spurious unseal. A stale pending-valid state shows as a write enable on a second execute strobe, one cycle after the first. Flag tables evaluated on the wrong term order or on post-update values give wrong new flags in the same execute cycle. The directed scenarios choose flag inputs and table bits so that each term changes the result.

// File: rtl/dock_set_pkg.sv
package dock_set_pkg;

  typedef enum logic [3:0] {
    ACT_NONE,
    ACT_OLC_PAY,
    ACT_OLC_DATA,
    ACT_OLC_DEC,
    ACT_ILC_PAY,
    ACT_ILC_DATA,
    ACT_ILC_INF,
    ACT_TAPL_PAY,
    ACT_DATA_ZX,
    ACT_DATA_OX,
    ACT_FLAGS
  } set_act_e;

  localparam int unsigned SRC_W = 2;
  localparam int unsigned DST_W = 3;

  function automatic set_act_e decode_set(input logic [SRC_W-1:0] src,
                                          input logic [DST_W-1:0] dst);
    set_act_e a;
    a = ACT_NONE;
    unique case (dst)
      3'b000: begin
        if (src == 2'b00) a = ACT_OLC_PAY;
        else if (src == 2'b01) a = ACT_OLC_DATA;
        else if (src == 2'b10) a = ACT_OLC_DEC;
      end
      3'b001: begin
        if (src == 2'b00) a = ACT_ILC_PAY;
        else if (src == 2'b01) a = ACT_ILC_DATA;
        else if (src == 2'b10) a = ACT_ILC_INF;
      end
      3'b010: if (src == 2'b00) a = ACT_TAPL_PAY;
      3'b100: begin
        if (src == 2'b01) a = ACT_DATA_ZX;
        else if (src == 2'b10) a = ACT_DATA_OX;
      end
      3'b111: a = ACT_FLAGS;
      default: a = ACT_NONE;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/dock_set_capture.sv
module dock_set_capture
  import dock_set_pkg::*;
#(
  parameter int unsigned DATA_W = 37,
  parameter int unsigned PAY_W  = 14
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      load_i,
  input  logic [SRC_W-1:0]          src_i,
  input  logic [DST_W-1:0]          dst_i,
  input  logic [PAY_W-1:0]          pay_i,
  input  logic                      exec_i,
  output set_act_e                  act_o,
  output logic                      valid_o,
  output logic [DATA_W-1:0]         lit_o
);
  localparam int unsigned EXT_W = DATA_W - PAY_W;

  set_act_e          act_d, act_q;
  logic [DATA_W-1:0] lit_d, lit_q;
  logic              valid_q;

  always_comb begin
    act_d = decode_set(src_i, dst_i);
    if (act_d == ACT_DATA_OX) lit_d = {{EXT_W{1'b1}}, pay_i};
    else                      lit_d = {{EXT_W{1'b0}}, pay_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= ACT_NONE;
      lit_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      if (load_i) begin
        act_q   <= act_d;
        lit_q   <= lit_d;
        valid_q <= 1'b1;
      end else if (exec_i) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign act_o   = act_q;
  assign valid_o = valid_q;
  assign lit_o   = lit_q;

  // R6
  lit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(lit_q));

endmodule

// File: rtl/dock_flag_eval.sv
module dock_flag_eval (
  input  logic [5:0] tt_i,
  input  logic       a_i,
  input  logic       b_i,
  input  logic       c_i,
  output logic       next_o
);
  logic [5:0] terms;
  assign terms  = {a_i, ~a_i, b_i, ~b_i, c_i, ~c_i};
  assign next_o = |(tt_i & terms);
endmodule

// File: rtl/dock_set_route.sv
module dock_set_route
  import dock_set_pkg::*;
#(
  parameter int unsigned DATA_W = 37,
  parameter int unsigned OLC_W  = 6,
  parameter int unsigned ILC_W  = 6,
  parameter int unsigned TAPL_W = 11
) (
  input  set_act_e                  act_i,
  input  logic                      fire_i,
  input  logic [DATA_W-1:0]         lit_i,
  input  logic [DATA_W-1:0]         data_i,
  input  logic [OLC_W-1:0]          olc_i,
  output logic                      olc_we_o,
  output logic [OLC_W-1:0]          olc_o,
  output logic                      ilc_we_o,
  output logic [ILC_W-1:0]          ilc_o,
  output logic                      ilc_inf_o,
  output logic                      tapl_we_o,
  output logic [TAPL_W-1:0]         tapl_o,
  output logic                      data_we_o,
  output logic [DATA_W-1:0]         data_o,
  output logic                      flags_we_o
);
  always_comb begin
    olc_we_o   = 1'b0;
    olc_o      = '0;
    ilc_we_o   = 1'b0;
    ilc_o      = '0;
    ilc_inf_o  = 1'b0;
    tapl_we_o  = 1'b0;
    tapl_o     = lit_i[TAPL_W-1:0];
    data_we_o  = 1'b0;
    data_o     = lit_i;
    flags_we_o = 1'b0;
    if (fire_i) begin
      unique case (act_i)
        ACT_OLC_PAY:  begin olc_we_o = 1'b1; olc_o = lit_i[OLC_W-1:0]; end
        ACT_OLC_DATA: begin olc_we_o = 1'b1; olc_o = data_i[OLC_W-1:0]; end
        ACT_OLC_DEC:  begin
          olc_we_o = 1'b1;
          olc_o    = (olc_i == '0) ? '0 : olc_i - OLC_W'(1);
        end
        ACT_ILC_PAY:  begin ilc_we_o = 1'b1; ilc_o = lit_i[ILC_W-1:0]; end
        ACT_ILC_DATA: begin ilc_we_o = 1'b1; ilc_o = data_i[ILC_W-1:0]; end
        ACT_ILC_INF:  begin ilc_we_o = 1'b1; ilc_inf_o = 1'b1; end
        ACT_TAPL_PAY: tapl_we_o  = 1'b1;
        ACT_DATA_ZX,
        ACT_DATA_OX:  data_we_o  = 1'b1;
        ACT_FLAGS:    flags_we_o = 1'b1;
        default:      ;
      endcase
    end
  end
endmodule

// File: rtl/dock_set_unit.sv
module dock_set_unit
  import dock_set_pkg::*;
#(
  parameter int unsigned DATA_W = 37,
  parameter int unsigned PAY_W  = 14,
  parameter int unsigned OLC_W  = 6,
  parameter int unsigned ILC_W  = 6,
  parameter int unsigned TAPL_W = 11
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      load_i,
  input  logic [SRC_W+DST_W+PAY_W-1:0] op_i,
  input  logic                      exec_i,
  input  logic [DATA_W-1:0]         data_i,
  input  logic [OLC_W-1:0]          olc_i,
  input  logic                      flag_a_i,
  input  logic                      flag_b_i,
  input  logic                      flag_c_i,
  output logic                      olc_we_o,
  output logic [OLC_W-1:0]          olc_o,
  output logic                      unseal_o,
  output logic                      ilc_we_o,
  output logic [ILC_W-1:0]          ilc_o,
  output logic                      ilc_inf_o,
  output logic                      tapl_we_o,
  output logic [TAPL_W-1:0]         tapl_o,
  output logic                      data_we_o,
  output logic [DATA_W-1:0]         data_o,
  output logic                      flags_we_o,
  output logic                      flag_a_o,
  output logic                      flag_b_o
);
  localparam int unsigned DST_LO = PAY_W;
  localparam int unsigned SRC_LO = PAY_W + DST_W;
  localparam int unsigned N_FLAG = 2;
  localparam int unsigned TT_W   = 6;

  set_act_e          act;
  logic              valid;
  logic [DATA_W-1:0] lit;
  logic              fire;
  logic [N_FLAG-1:0] next_flag;

  dock_set_capture #(.DATA_W(DATA_W), .PAY_W(PAY_W)) u_capture (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .src_i   (op_i[SRC_LO +: SRC_W]),
    .dst_i   (op_i[DST_LO +: DST_W]),
    .pay_i   (op_i[PAY_W-1:0]),
    .exec_i  (exec_i),
    .act_o   (act),
    .valid_o (valid),
    .lit_o   (lit)
  );

  assign fire = exec_i & valid;

  dock_set_route #(
    .DATA_W(DATA_W), .OLC_W(OLC_W), .ILC_W(ILC_W), .TAPL_W(TAPL_W)
  ) u_route (
    .act_i      (act),
    .fire_i     (fire),
    .lit_i      (lit),
    .data_i     (data_i),
    .olc_i      (olc_i),
    .olc_we_o   (olc_we_o),
    .olc_o      (olc_o),
    .ilc_we_o   (ilc_we_o),
    .ilc_o      (ilc_o),
    .ilc_inf_o  (ilc_inf_o),
    .tapl_we_o  (tapl_we_o),
    .tapl_o     (tapl_o),
    .data_we_o  (data_we_o),
    .data_o     (data_o),
    .flags_we_o (flags_we_o)
  );

  // flag A table sits above flag B table in the payload
  for (genvar g = 0; g < N_FLAG; g++) begin : g_flag
    dock_flag_eval u_eval (
      .tt_i   (lit[(N_FLAG-1-g)*TT_W +: TT_W]),
      .a_i    (flag_a_i),
      .b_i    (flag_b_i),
      .c_i    (flag_c_i),
      .next_o (next_flag[g])
    );
  end

  assign flag_a_o = next_flag[0];
  assign flag_b_o = next_flag[1];
  assign unseal_o = olc_we_o && (olc_o == '0);

  // R10
  wr_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({olc_we_o, ilc_we_o, tapl_we_o, data_we_o, flags_we_o}));

  // R6
  idle_no_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_i |-> !(olc_we_o || ilc_we_o || tapl_we_o || data_we_o || flags_we_o));

  // R9
  single_exec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && $past(exec_i) && !$past(load_i))
      |-> !(olc_we_o || ilc_we_o || tapl_we_o || data_we_o || flags_we_o));

  // R2
  ilc_inf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ilc_inf_o |-> (ilc_we_o && ilc_o == '0));

  // R7
  unseal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unseal_o |-> (exec_i && olc_we_o));

endmodule

// File: tb/dock_set_unit_bench.sv
`timescale 1ns/1ps
module dock_set_unit_bench;
  localparam int unsigned DATA_W = 37;
  localparam int unsigned PAY_W  = 14;
  localparam int unsigned OLC_W  = 6;
  localparam int unsigned ILC_W  = 6;
  localparam int unsigned TAPL_W = 11;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              load_i = 1'b0;
  logic [18:0]       op_i = '0;
  logic              exec_i = 1'b0;
  logic [DATA_W-1:0] data_i = '0;
  logic [OLC_W-1:0]  olc_i = '0;
  logic              flag_a_i = 1'b0, flag_b_i = 1'b0, flag_c_i = 1'b0;
  logic              olc_we_o, unseal_o, ilc_we_o, ilc_inf_o, tapl_we_o;
  logic              data_we_o, flags_we_o, flag_a_o, flag_b_o;
  logic [OLC_W-1:0]  olc_o;
  logic [ILC_W-1:0]  ilc_o;
  logic [TAPL_W-1:0] tapl_o;
  logic [DATA_W-1:0] data_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  dock_set_unit u_dock_set_unit (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] wes();
    return {olc_we_o, ilc_we_o, tapl_we_o, data_we_o, flags_we_o};
  endfunction

  task automatic load_op(input logic [1:0] src, input logic [2:0] dst,
                         input logic [13:0] pay);
    @(negedge clk_i);
    op_i = {src, dst, pay}; load_i = 1'b1; exec_i = 1'b0;
    @(negedge clk_i);
    load_i = 1'b0;
    #1;
  endtask

  task automatic exec_on();
    exec_i = 1'b1;
    #1;
  endtask

  task automatic exec_off();
    @(negedge clk_i);
    exec_i = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    chk(wes() == 5'b0 && !unseal_o, "R6 reset no write", wes(), 0);
    exec_on();
    chk(wes() == 5'b0, "R9 exec with nothing loaded", wes(), 0);
    exec_off();
  endtask

  task automatic t_olc();
    load_op(2'b00, 3'b000, 14'h0025);
    exec_on();
    chk(olc_we_o && olc_o == 6'h25 && !unseal_o, "R1 olc from payload", olc_o, 6'h25);
    exec_off();
    data_i = 37'h1_2345_6789;
    load_op(2'b01, 3'b000, 14'h0000);
    exec_on();
    chk(olc_we_o && olc_o == 6'h09, "R1 olc from data", olc_o, 6'h09);
    exec_off();
    olc_i = 6'h10;
    load_op(2'b10, 3'b000, 14'h0000);
    exec_on();
    chk(olc_we_o && olc_o == 6'h0f && !unseal_o, "R1 olc decrement", olc_o, 6'h0f);
    exec_off();
  endtask

  task automatic t_unseal();
    olc_i = 6'h00;
    load_op(2'b10, 3'b000, 14'h0000);
    exec_on();
    chk(olc_we_o && olc_o == 0 && unseal_o, "R7 decrement saturates and unseals", {olc_o, unseal_o}, 1);
    exec_off();
    olc_i = 6'h01;
    load_op(2'b10, 3'b000, 14'h0000);
    exec_on();
    chk(unseal_o && olc_o == 0, "R7 decrement to zero unseals", unseal_o, 1);
    exec_off();
    load_op(2'b00, 3'b000, 14'h0040);
    exec_on();
    chk(unseal_o && olc_o == 0, "R7 payload low bits zero unseals", unseal_o, 1);
    exec_off();
  endtask

  task automatic t_ilc();
    load_op(2'b00, 3'b001, 14'h3fc7);
    exec_on();
    chk(ilc_we_o && ilc_o == 6'h07 && !ilc_inf_o, "R2 ilc from payload", ilc_o, 6'h07);
    exec_off();
    data_i = 37'h0_0000_003a;
    load_op(2'b01, 3'b001, 14'h0000);
    exec_on();
    chk(ilc_we_o && ilc_o == 6'h3a, "R2 ilc from data", ilc_o, 6'h3a);
    exec_off();
    load_op(2'b10, 3'b001, 14'h0000);
    exec_on();
    chk(ilc_we_o && ilc_inf_o, "R2 ilc infinity", {ilc_we_o, ilc_inf_o}, 2'b11);
    exec_off();
  endtask

  task automatic t_tapl();
    load_op(2'b00, 3'b010, 14'h1abc);
    exec_on();
    chk(tapl_we_o && tapl_o == 11'h2bc, "R3 path latch", tapl_o, 11'h2bc);
    exec_off();
  endtask

  task automatic t_data();
    logic [DATA_W-1:0] ex;
    load_op(2'b01, 3'b100, 14'h2001);
    exec_on();
    ex = 37'h2001;
    chk(data_we_o && data_o == ex, "R4 zero extend", data_o, ex);
    exec_off();
    load_op(2'b10, 3'b100, 14'h0005);
    exec_on();
    ex = {{23{1'b1}}, 14'h0005};
    chk(data_we_o && data_o == ex, "R4 one extend", data_o, ex);
    exec_off();
  endtask

  task automatic t_flags();
    flag_a_i = 1'b1; flag_b_i = 1'b0; flag_c_i = 1'b1;
    // A table: C term only -> 1 ; B table: not-A only -> 0
    load_op(2'b00, 3'b111, {2'b00, 6'b000010, 6'b010000});
    exec_on();
    chk(flags_we_o && flag_a_o == 1 && flag_b_o == 0, "R5 tables C / notA",
        {flag_a_o, flag_b_o}, 2'b10);
    exec_off();
    // A table: not-C | B -> 0 ; B table: not-B -> 1
    load_op(2'b11, 3'b111, {2'b00, 6'b001001, 6'b000100});
    exec_on();
    chk(flags_we_o && flag_a_o == 0 && flag_b_o == 1, "R5 tables notC|B / notB",
        {flag_a_o, flag_b_o}, 2'b01);
    exec_off();
  endtask

  task automatic t_capture();
    load_op(2'b01, 3'b100, 14'h0abc);
    chk(wes() == 5'b0, "R6 no write before execute", wes(), 0);
    op_i = {2'b00, 3'b000, 14'h0011};
    @(negedge clk_i); #1;
    exec_on();
    chk(data_we_o && !olc_we_o && data_o == 37'h0abc, "R6 captured literal kept", data_o, 37'h0abc);
    exec_off();
  endtask

  task automatic t_unlisted();
    logic [4:0] bad [4];
    bad[0] = {2'b11, 3'b000}; bad[1] = {2'b01, 3'b010};
    bad[2] = {2'b00, 3'b100}; bad[3] = {2'b10, 3'b101};
    for (int i = 0; i < 4; i++) begin
      load_op(bad[i][4:3], bad[i][2:0], 14'h0000);
      exec_on();
      chk(wes() == 5'b0 && !unseal_o, "R8 unlisted combination", wes(), 0);
      exec_off();
    end
  endtask

  task automatic t_once();
    load_op(2'b00, 3'b010, 14'h0123);
    exec_on();
    chk(tapl_we_o, "R9 first execute writes", tapl_we_o, 1);
    @(negedge clk_i); #1;
    chk(wes() == 5'b0, "R9 second execute ignored", wes(), 0);
    exec_off();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i); #1;
    t_reset();
    t_olc();
    t_unseal();
    t_ilc();
    t_tapl();
    t_data();
    t_flags();
    t_capture();
    t_unlisted();
    t_once();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule